// File: doc/BRIEF.md
# Two-Wire Serial Target Controller

This block answers a two-wire bus master as an addressed target. It oversamples the clock (SCL) and data (SDA) lines through synchronizers. It spots START, repeated START and STOP on the sampled lines and compares the first byte after a START with a programmable 7-bit own address. On a match it acknowledges and then takes one of two paths. For a read, it shifts out bytes from a one-entry transmit holding register. For a write, it takes in bytes into a receive register. The block only answers; every START, repeated START and STOP comes from the master. SDA is only ever pulled low through an output enable, in open-drain style.

A host drives the block through level and pulse signals that act like a small register set. It sets the own address, a target-enable level and a master-disable level. It writes the holding register and reads the receive register. A status-read strobe clears the sticky flags. The status flags are: access active, direction, end of access, transmit ready, transmit complete, not-acknowledged and receive ready.

The control is one state machine with these states:

- S_IDLE: no access.
- S_ADDR: shifting in the address byte.
- S_AACK: address acknowledge.
- S_TX: shifting out a byte.
- S_TACK: sampling the master's acknowledge.
- S_RX: shifting in a byte.
- S_RACK: acknowledging a received byte.
- S_WAIT: ignoring the bus until the next condition.

Transitions:

- From any state, STOP goes to S_IDLE and START goes to S_ADDR. Dropping either enable also goes to S_IDLE.
- S_ADDR goes to S_AACK on the eighth rising clock if the address matches, or to S_WAIT if it does not.
- S_AACK goes to S_TX or S_RX at the falling edge that ends the acknowledge clock.
- S_TX goes to S_TACK after its eighth bit.
- S_TACK goes to S_WAIT on NACK, or back to S_TX at the falling edge after an ACK.
- S_RX goes to S_RACK on the eighth rising clock.
- S_RACK goes back to S_RX at the falling edge that ends the acknowledge clock.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, every status flag reads 0 except transmit-ready, which reads 1, and SDA is not pulled.
- R2: The address byte is seven address bits, most significant first, followed by a direction bit (1 = master reads). If the address equals own_addr_i, the target pulls SDA low for the ninth clock, sets acc_o and shows the direction bit on dir_o. On a mismatch it does not acknowledge and acc_o stays 0.
- R3: acc_o stays 1 until a STOP or a repeated START is seen. At that point acc_o clears and eoacc_o is set.
- R4: In a write access every received byte is acknowledged. The byte appears on rhr_data_o, most significant bit first on the wire, and rxrdy_o is set; a pulse on rhr_rd_i clears rxrdy_o.
- R5: In a read access the target sends, most significant bit first, the byte held in the holding register. If no byte has been written since the last load, it sends 8'hFF.
- R6: A write to the holding register clears txrdy_o. When the master's acknowledge bit (ACK or NACK) is sampled, txrdy_o is set again, unless a newer byte is already waiting.
- R7: A master NACK after a transmitted byte sets nack_o. The target then leaves SDA released until the next START.
- R8: When a read access ends, txcomp_o is set and acc_o is cleared.
- R9: A pulse on stat_rd_i clears eoacc_o, txcomp_o and nack_o.
- R10: Unless both tgt_en_i and mst_dis_i are 1, the target never acknowledges and never sets acc_o.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed bus clock line |
| sda_i | input | 1 | Sensed bus data line |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | ADDR_W | Own target address |
| tgt_en_i | input | 1 | Target mode enable |
| mst_dis_i | input | 1 | Master mode disabled |
| thr_wr_i | input | 1 | Write strobe for the holding register |
| thr_data_i | input | DATA_W | Byte for the holding register |
| rhr_rd_i | input | 1 | Read strobe for the receive register |
| rhr_data_o | output | DATA_W | Last received byte |
| stat_rd_i | input | 1 | Status read strobe, clears sticky flags |
| acc_o | output | 1 | Addressed access in progress |
| dir_o | output | 1 | 1 = master reads |
| eoacc_o | output | 1 | End of access seen |
| txrdy_o | output | 1 | Holding register may be written |
| txcomp_o | output | 1 | Read access completed |
| nack_o | output | 1 | Master did not acknowledge a byte |
| rxrdy_o | output | 1 | Received byte waiting |

## Verification
The assertions assume a well-behaved master and host:

- The master moves SDA only while SCL is low, except when it makes a START or a STOP.
- The master holds each line level for many system clocks, so the synchronizers see every edge.
- It NACKs the last byte it reads before it issues STOP or repeated START.
- The enables change only while the bus is idle.

The bench drives a bus model in which each quarter bit lasts ten clocks. Data changes only in the SCL-low half. The enables are toggled between transfers. Every read is closed with a NACK, so the drive-timing and flag-causality properties always see legal traffic.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_TX,
        S_TACK,
        S_RX,
        S_RACK,
        S_WAIT
    } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p, sda_p;

    i2ct_sync #(.STAGES(STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_o));
    i2ct_sync #(.STAGES(STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_o;
            sda_p <= sda_o;
        end
    end

    assign scl_rise_o = scl_o & ~scl_p;
    assign scl_fall_o = ~scl_o & scl_p;
    assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
    assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2ct_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              tgt_en_i,
    input  logic              mst_dis_i,
    input  logic              thr_wr_i,
    input  logic [DATA_W-1:0] thr_data_i,
    input  logic              rhr_rd_i,
    output logic [DATA_W-1:0] rhr_data_o,
    input  logic              stat_rd_i,
    output logic              acc_o,
    output logic              dir_o,
    output logic              eoacc_o,
    output logic              txrdy_o,
    output logic              txcomp_o,
    output logic              nack_o,
    output logic              rxrdy_o
);
    localparam int FRAME_W = (DATA_W > ADDR_W + 1) ? DATA_W : ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2ct_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    tgt_state_e          state_q, state_n;
    logic                ph_q;
    logic [CNT_W-1:0]    bitcnt_q;
    logic [FRAME_W-1:0]  rx_sh_q, rx_next;
    logic [DATA_W-1:0]   tx_sh_q, thr_q, rhr_q;
    logic                thr_full_q, active, addr_hit, restart;
    logic                acc_q, dir_q, eoacc_q, txrdy_q, txcomp_q, nack_q, rxrdy_q;

    assign active   = tgt_en_i & mst_dis_i;
    assign rx_next  = {rx_sh_q[FRAME_W-2:0], sda_s};
    assign addr_hit = (rx_sh_q[ADDR_W-1:0] == own_addr_i);
    assign restart  = (state_n != state_q) | start_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!active || stop_det) begin
            state_n = S_IDLE;
        end else if (start_det) begin
            state_n = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE, S_WAIT: state_n = state_q;
                S_ADDR: if (scl_rise && bitcnt_q == ADDR_LAST)
                            state_n = addr_hit ? S_AACK : S_WAIT;
                S_AACK: if (scl_fall && ph_q)
                            state_n = dir_q ? S_TX : S_RX;
                S_TX:   if (scl_fall && bitcnt_q == DATA_LAST)
                            state_n = S_TACK;
                S_TACK: if (scl_rise && !ph_q && sda_s)
                            state_n = S_WAIT;
                        else if (scl_fall && ph_q)
                            state_n = S_TX;
                S_RX:   if (scl_rise && bitcnt_q == DATA_LAST)
                            state_n = S_RACK;
                S_RACK: if (scl_fall && ph_q)
                            state_n = S_RX;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // Output logic: open-drain SDA drive
    always_comb begin
        unique case (state_q)
            S_AACK, S_RACK: sda_oe_o = ph_q;
            S_TX:           sda_oe_o = ~tx_sh_q[DATA_W-1];
            default:        sda_oe_o = 1'b0;
        endcase
    end

    // Datapath and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 1'b0; bitcnt_q <= '0; rx_sh_q <= '0; tx_sh_q <= '1;
            thr_q <= '0; rhr_q <= '0; thr_full_q <= 1'b0;
            acc_q <= 1'b0; dir_q <= 1'b0; eoacc_q <= 1'b0; txrdy_q <= 1'b1;
            txcomp_q <= 1'b0; nack_q <= 1'b0; rxrdy_q <= 1'b0;
        end else begin
            if (stat_rd_i) begin
                eoacc_q  <= 1'b0;
                txcomp_q <= 1'b0;
                nack_q   <= 1'b0;
            end
            if (rhr_rd_i) rxrdy_q <= 1'b0;

            if (restart) begin
                ph_q     <= 1'b0;
                bitcnt_q <= '0;
            end else if ((state_q == S_AACK || state_q == S_RACK) && scl_fall) begin
                ph_q <= 1'b1;
            end else if (state_q == S_TACK && scl_rise) begin
                ph_q <= 1'b1;
            end else if ((state_q == S_ADDR || state_q == S_RX) && scl_rise) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end else if (state_q == S_TX && scl_fall) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end

            if ((state_q == S_ADDR || state_q == S_RX) && scl_rise) rx_sh_q <= rx_next;

            if (state_n == S_TX && state_q != S_TX) begin
                tx_sh_q    <= thr_full_q ? thr_q : '1;
                thr_full_q <= 1'b0;
            end else if (state_q == S_TX && scl_fall) begin
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
            end

            if (state_q == S_TACK && scl_rise && !ph_q && active && !start_det && !stop_det) begin
                txrdy_q <= ~thr_full_q;
                if (sda_s) nack_q <= 1'b1;
            end

            if (state_q == S_ADDR && state_n == S_AACK) begin
                acc_q <= 1'b1;
                dir_q <= rx_next[0];
            end

            if (state_q == S_RX && state_n == S_RACK) begin
                rhr_q   <= rx_next[DATA_W-1:0];
                rxrdy_q <= 1'b1;
            end

            if (!active) begin
                acc_q <= 1'b0;
            end else if ((start_det || stop_det) && acc_q) begin
                acc_q   <= 1'b0;
                eoacc_q <= 1'b1;
                if (dir_q) txcomp_q <= 1'b1;
            end

            if (thr_wr_i) begin
                thr_q      <= thr_data_i;
                thr_full_q <= 1'b1;
                txrdy_q    <= 1'b0;
            end
        end
    end

    assign rhr_data_o = rhr_q;
    assign acc_o      = acc_q;
    assign dir_o      = dir_q;
    assign eoacc_o    = eoacc_q;
    assign txrdy_o    = txrdy_q;
    assign txcomp_o   = txcomp_q;
    assign nack_o     = nack_q;
    assign rxrdy_o    = rxrdy_q;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic tgt_en_i,
    input logic mst_dis_i,
    input logic thr_wr_i,
    input logic sda_oe_o,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic acc_o,
    input logic eoacc_o,
    input logic txcomp_o,
    input logic txrdy_o
);
    logic on;
    assign on = tgt_en_i & mst_dis_i;

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (!sda_oe_o && !acc_o));

    assert_acc_ends_on_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_o) |-> $past(start_det || stop_det || !on));

    assert_eoacc_after_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoacc_o) |-> $past(acc_o));

    assert_txcomp_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txcomp_o) |-> (eoacc_o && !acc_o));

    assert_thr_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i |=> !txrdy_o);

    assert_drive_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(sda_oe_o) || $fell(sda_oe_o)) && $past(on) && !$past(start_det || stop_det))
            |-> !scl_s);
endmodule

bind i2c_target_ctrl i2ct_checker u_i2ct_checker (
    .clk(clk), .rst_n(rst_n), .tgt_en_i(tgt_en_i), .mst_dis_i(mst_dis_i),
    .thr_wr_i(thr_wr_i), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .acc_o(acc_o),
    .eoacc_o(eoacc_o), .txcomp_o(txcomp_o), .txrdy_o(txrdy_o)
);

// File: tb/i2c_target_ctrl_bench.sv
module i2c_target_ctrl_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_pull = 1'b0, m_sda_pull = 1'b0;
    logic sda_oe;
    logic scl_line, sda_line;
    logic [6:0] own_addr = 7'h00;
    logic tgt_en = 1'b0, mst_dis = 1'b0;
    logic thr_wr = 1'b0, rhr_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0] thr_data = 8'h00, rhr_data;
    logic acc, dir, eoacc, txrdy, txcomp, nack, rxrdy;
    int n_chk = 0, n_fail = 0, drive_viol = 0;

    always #5 clk = ~clk;

    assign scl_line = ~m_scl_pull;
    assign sda_line = ~(m_sda_pull | sda_oe);

    i2c_target_ctrl u_i2c_target_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .own_addr_i(own_addr), .tgt_en_i(tgt_en),
        .mst_dis_i(mst_dis), .thr_wr_i(thr_wr), .thr_data_i(thr_data),
        .rhr_rd_i(rhr_rd), .rhr_data_o(rhr_data), .stat_rd_i(stat_rd),
        .acc_o(acc), .dir_o(dir), .eoacc_o(eoacc), .txrdy_o(txrdy),
        .txcomp_o(txcomp), .nack_o(nack), .rxrdy_o(rxrdy)
    );

    // R11 monitor: the target's drive may only move while SCL is low
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl_line) drive_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx(input bit loaded, input logic [7:0] d);
        return loaded ? d : 8'hFF;
    endfunction

    function automatic logic [6:0] other_addr(input logic [6:0] a, input logic [6:0] r);
        return a ^ ((r == 7'h0) ? 7'h1 : r);
    endfunction

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic m_start();
        m_sda_pull = 1'b0; qw();
        m_scl_pull = 1'b0; qw();
        m_sda_pull = 1'b1; qw();
        m_scl_pull = 1'b1; qw();
    endtask

    task automatic m_stop();
        m_sda_pull = 1'b1; qw();
        m_scl_pull = 1'b0; qw();
        m_sda_pull = 1'b0; qw(); qw();
    endtask

    task automatic m_bit_out(input bit b);
        m_sda_pull = ~b; qw();
        m_scl_pull = 1'b0; qw(); qw();
        m_scl_pull = 1'b1; qw();
    endtask

    task automatic m_bit_in(output bit b);
        m_sda_pull = 1'b0; qw();
        m_scl_pull = 1'b0; qw();
        b = sda_line; qw();
        m_scl_pull = 1'b1; qw();
    endtask

    task automatic m_byte_out(input logic [7:0] v, output bit acked);
        bit r;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(r);
        acked = ~r;
    endtask

    task automatic m_byte_in(output logic [7:0] v);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(r);
            v[i] = r;
        end
    endtask

    task automatic host_thr(input logic [7:0] d);
        @(negedge clk); thr_wr = 1'b1; thr_data = d;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic host_rhr();
        @(negedge clk); rhr_rd = 1'b1;
        @(negedge clk); rhr_rd = 1'b0;
    endtask

    task automatic host_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input int nbytes);
        bit ak;
        logic [7:0] d;
        m_start();
        m_byte_out({own_addr, 1'b0}, ak);
        chk("R2 write address ack", ak, 1);
        chk("R2 acc after match", acc, 1);
        chk("R2 dir write", dir, 0);
        for (int k = 0; k < nbytes; k++) begin
            d = 8'($urandom);
            m_byte_out(d, ak);
            chk("R4 data byte ack", ak, 1);
            chk("R4 rxrdy set", rxrdy, 1);
            chk("R4 received byte", rhr_data, d);
            host_rhr();
            chk("R4 rxrdy cleared by read", rxrdy, 0);
        end
    endtask

    task automatic do_read(input int nbytes, input bit preload);
        bit ak;
        bit loaded, wr_next;
        logic [7:0] pend, got;
        pend = 8'($urandom);
        loaded = preload;
        if (preload) begin
            host_thr(pend);
            chk("R6 txrdy cleared by write", txrdy, 0);
        end
        m_start();
        m_byte_out({own_addr, 1'b1}, ak);
        chk("R2 read address ack", ak, 1);
        chk("R2 dir read", dir, 1);
        for (int k = 0; k < nbytes; k++) begin
            m_byte_in(got);
            chk("R5 transmitted byte", got, exp_tx(loaded, pend));
            wr_next = (k < nbytes - 1) && ($urandom % 2 == 1);
            if (wr_next) begin
                pend = 8'($urandom);
                host_thr(pend);
            end
            loaded = wr_next;
            if (k == nbytes - 1) begin
                m_bit_out(1'b1);
                chk("R7 nack flag", nack, 1);
                chk("R6 txrdy after nack", txrdy, 1);
                chk("R7 sda released after nack", sda_oe, 0);
            end else begin
                m_bit_out(1'b0);
                chk("R6 txrdy after ack", txrdy, !wr_next);
                chk("R7 no nack on ack", nack, 0);
            end
        end
        m_stop();
        chk("R8 txcomp at end", txcomp, 1);
        chk("R8 acc cleared", acc, 0);
        chk("R3 eoacc after read", eoacc, 1);
        host_stat();
        chk("R9 flags cleared", {eoacc, txcomp, nack}, 3'b000);
    endtask

    task automatic do_miss(input bit rw);
        bit ak;
        m_start();
        m_byte_out({other_addr(own_addr, 7'($urandom)), rw}, ak);
        chk("R2 no ack on mismatch", ak, 0);
        chk("R2 acc stays low", acc, 0);
        m_stop();
        chk("R2 no eoacc on mismatch", eoacc, 0);
    endtask

    initial begin
        int seed;
        bit ak;
        logic [7:0] got;
        seed = int'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", {acc, dir, eoacc, txcomp, nack, rxrdy}, 6'b0);
        chk("R1 reset txrdy", txrdy, 1);
        chk("R1 reset sda drive", sda_oe, 0);

        own_addr = 7'($urandom);
        tgt_en = 1'b1; mst_dis = 1'b1;

        // directed write then stop
        do_write(3);
        m_stop();
        chk("R3 acc cleared by stop", acc, 0);
        chk("R3 eoacc by stop", eoacc, 1);
        chk("R8 no txcomp after write", txcomp, 0);
        host_stat();
        chk("R9 eoacc cleared", eoacc, 0);

        // mismatch
        do_miss(1'b0);
        do_miss(1'b1);

        // directed read: preloaded byte, then empty refill, then a late write
        do_read(3, 1'b1);
        do_read(1, 1'b0);

        // repeated START from write into read
        do_write(1);
        m_start();
        chk("R3 acc cleared by repeated start", acc, 0);
        chk("R3 eoacc by repeated start", eoacc, 1);
        m_byte_out({own_addr, 1'b1}, ak);
        chk("R2 ack after repeated start", ak, 1);
        chk("R3 acc set again", acc, 1);
        m_byte_in(got);
        chk("R5 empty holding sends FF", got, 8'hFF);
        m_bit_out(1'b1);
        m_stop();
        chk("R8 txcomp after repeated read", txcomp, 1);
        host_stat();

        // disabled target
        tgt_en = 1'b0;
        m_start();
        m_byte_out({own_addr, 1'b0}, ak);
        chk("R10 no ack when target disabled", ak, 0);
        chk("R10 no acc when target disabled", acc, 0);
        m_stop();
        tgt_en = 1'b1; mst_dis = 1'b0;
        m_start();
        m_byte_out({own_addr, 1'b1}, ak);
        chk("R10 no ack when master enabled", ak, 0);
        m_stop();
        chk("R10 no eoacc when inactive", eoacc, 0);
        mst_dis = 1'b1;

        // constrained random traffic
        for (int it = 0; it < 12; it++) begin
            int kind;
            kind = $urandom % 4;
            if (kind == 0) begin
                do_miss(1'($urandom));
            end else if (kind == 1) begin
                do_write(1 + $urandom % 3);
                m_stop();
                chk("R3 eoacc after random write", eoacc, 1);
                host_stat();
            end else begin
                do_read(1 + $urandom % 3, 1'($urandom));
            end
        end

        chk("R11 drive changes only with SCL low", drive_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1-watchdog: run hung actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule